// File: doc/BRIEF.md
# Fetch-Group Next-Address Predictor

This block tells the fetch unit which aligned group of four instructions to fetch next. It does this before decode has seen the current group. The lookup is combinational. The current fetch address goes in, and in the same cycle a predicted successor address comes out. That result can register straight into the fetch address latch. The table is fully associative. Each entry holds the tag of a group and the group index of the successor fetched after it. An address that no entry matches falls back to the next sequential group.

Branch resolution corrects the table, and so does the more accurate branch predictor at decode. Either one drives a single update port whenever the successor it finds for a group differs from the one fetch followed. Because the later predictor writes through this port, its answer replaces the flow prediction for that group. An update whose group is already stored rewrites that entry's pointer in place. An update for an unknown group claims an entry chosen round-robin. Writes take effect at the clock edge, so a lookup in the cycle of an update still sees the old contents.

Top module: `fgp_next_group`

## Requirements
- R1: After the synchronous active-low reset, every lookup misses (`pred_hit` low) until an update has been applied.
- R2: On a miss, `pred_addr` is the base of the following group: the lookup address with its two low bits dropped, plus 4. The result wraps modulo 2^PC_W, and the two low bits of the output are zero.
- R3: After an update for a group, a lookup in any later cycle, at any of the four addresses in that group, returns `pred_hit` high. `pred_addr` is then the group base of the update target.
- R4: A lookup in the same cycle as an update to the same group returns the contents from before the update: a miss if the group was absent, otherwise the old pointer.
- R5: An update to a group already in the table rewrites only that entry's pointer. It allocates nothing and evicts nothing, and every other stored group keeps its pointer.
- R6: An update to a group not in the table writes entry slots in round-robin order: slot 0, then 1, up to ENTRIES-1, and then slot 0 again. Each such update evicts the group that was allocated longest ago.
- R7: The two low bits of `upd_addr` and `upd_tgt` are ignored. Entries are keyed and predicted per group of four instructions.
- R8: With ENTRIES = 32 (the default), 32 distinct groups can be held at once, each returning its own pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; clears all valid bits and the replacement pointer |
| lk_addr | input | PC_W | Current fetch address (instruction units) |
| pred_addr | output | PC_W | Predicted next fetch-group base address |
| pred_hit | output | 1 | Lookup matched a stored group |
| upd_en | input | 1 | Apply a correction this cycle |
| upd_addr | input | PC_W | Address inside the group whose successor is being corrected |
| upd_tgt | input | PC_W | Address inside the correct successor group |

## Verification
A wrong internal state shows up on the lookup outputs in the cycle that follows the faulty write. A lost or duplicated valid bit shows as a wrong `pred_hit` for that group. A corrupted pointer shows as a wrong `pred_addr`. A replacement pointer that moves when it should not shows up later, when an allocation evicts the wrong group. Sweeping every group address after each phase exposes all of these. Those phases are reset, a full fill, an in-place rewrite, and two wrap-around allocations.

// File: rtl/fgp_pkg.sv
// Shared constants and types for the fetch-group next-address predictor.
// Assumes a fetch group of a power-of-two number of instructions.
package fgp_pkg;
    localparam int GRP_INSNS = 4;
    localparam int GRP_OFS_W = $clog2(GRP_INSNS);

    typedef enum logic [1:0] {
        UPD_IDLE    = 2'd0,
        UPD_REWRITE = 2'd1,
        UPD_ALLOC   = 2'd2
    } upd_kind_e;
endpackage

// File: rtl/fgp_tag_store.sv
// Fully associative storage of group tags and successor group indices.
// Two compare ports: one for the lookup tag, one for the update tag.
// Assumes wr_sel is one-hot or zero; data words carry no reset, only valids do.
module fgp_tag_store #(
    parameter int ENTRIES = 32,
    parameter int TAG_W   = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TAG_W-1:0]         lk_tag,
    input  logic [TAG_W-1:0]         upd_tag,
    input  logic [ENTRIES-1:0]       wr_sel,
    input  logic [TAG_W-1:0]         wr_tgt,
    output logic [ENTRIES-1:0]       lk_match,
    output logic [ENTRIES-1:0]       upd_match,
    output logic [ENTRIES*TAG_W-1:0] tgt_flat
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic             vld_q;
        logic [TAG_W-1:0] tag_q;
        logic [TAG_W-1:0] tgt_q;

        // Valid bit: cleared by reset, set when the slot is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                vld_q <= 1'b0;
            else if (wr_sel[e])
                vld_q <= 1'b1;
        end

        // Tag and successor pointer capture on a selected write.
        always_ff @(posedge clk) begin
            if (wr_sel[e]) begin
                tag_q <= upd_tag;
                tgt_q <= wr_tgt;
            end
        end

        assign lk_match[e]               = vld_q && (tag_q == lk_tag);
        assign upd_match[e]              = vld_q && (tag_q == upd_tag);
        assign tgt_flat[e*TAG_W +: TAG_W] = tgt_q;
    end
endmodule

// File: rtl/fgp_onehot_mux.sv
// AND-OR selection of one word from a flattened array by a one-hot select.
// Assumes sel has at most one bit set; zero select yields zero.
module fgp_onehot_mux #(
    parameter int N = 32,
    parameter int W = 14
) (
    input  logic [N-1:0]   sel,
    input  logic [N*W-1:0] data,
    output logic [W-1:0]   q
);
    // OR together the words whose select bit is set.
    always_comb begin
        q = '0;
        for (int i = 0; i < N; i++) begin
            if (sel[i])
                q = q | data[i*W +: W];
        end
    end
endmodule

// File: rtl/fgp_rr_victim.sv
// Round-robin replacement pointer; advances by one slot per allocation.
// Assumes ENTRIES >= 2.
module fgp_rr_victim #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] victim
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // Pointer update: reset to slot 0, wrap after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            victim <= '0;
        else if (adv)
            victim <= (victim == LAST) ? '0 : victim + 1'b1;
    end
endmodule

// File: rtl/fgp_next_group.sv
// Fetch-group next-address predictor top. A combinational lookup of the current
// fetch group yields the stored successor group or, on a miss, the sequential
// one. An update rewrites an existing entry in place or allocates round-robin.
// Assumes addresses count instructions; updates take effect at the clock edge.
module fgp_next_group
    import fgp_pkg::*;
#(
    parameter int PC_W    = 16,
    parameter int ENTRIES = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_addr,
    output logic [PC_W-1:0] pred_addr,
    output logic            pred_hit,
    input  logic            upd_en,
    input  logic [PC_W-1:0] upd_addr,
    input  logic [PC_W-1:0] upd_tgt
);
    localparam int TAG_W = PC_W - GRP_OFS_W;
    localparam int IDX_W = $clog2(ENTRIES);

    logic [TAG_W-1:0]         lk_tag, upd_tag, tgt_tag, hit_tgt, seq_tag, nxt_tag;
    logic [ENTRIES-1:0]       lk_match, upd_match, victim_oh, wr_sel;
    logic [ENTRIES*TAG_W-1:0] tgt_flat;
    logic [IDX_W-1:0]         victim;
    logic                     alloc;
    upd_kind_e                upd_kind;

    assign lk_tag  = lk_addr[PC_W-1:GRP_OFS_W];
    assign upd_tag = upd_addr[PC_W-1:GRP_OFS_W];
    assign tgt_tag = upd_tgt[PC_W-1:GRP_OFS_W];

    // Classify the update: none, in-place rewrite, or fresh allocation.
    always_comb begin
        if (!upd_en)
            upd_kind = UPD_IDLE;
        else if (|upd_match)
            upd_kind = UPD_REWRITE;
        else
            upd_kind = UPD_ALLOC;
    end

    assign alloc = (upd_kind == UPD_ALLOC);

    // Decode the replacement pointer to a one-hot slot select.
    always_comb begin
        victim_oh         = '0;
        victim_oh[victim] = 1'b1;
    end

    // Choose which slot (if any) is written this cycle.
    always_comb begin
        case (upd_kind)
            UPD_REWRITE: wr_sel = upd_match;
            UPD_ALLOC:   wr_sel = victim_oh;
            default:     wr_sel = '0;
        endcase
    end

    fgp_tag_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_tag    (lk_tag),
        .upd_tag   (upd_tag),
        .wr_sel    (wr_sel),
        .wr_tgt    (tgt_tag),
        .lk_match  (lk_match),
        .upd_match (upd_match),
        .tgt_flat  (tgt_flat)
    );

    fgp_onehot_mux #(.N(ENTRIES), .W(TAG_W)) u_mux (
        .sel  (lk_match),
        .data (tgt_flat),
        .q    (hit_tgt)
    );

    fgp_rr_victim #(.ENTRIES(ENTRIES)) u_rr (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (alloc),
        .victim (victim)
    );

    assign seq_tag   = lk_tag + 1'b1;
    assign pred_hit  = |lk_match;
    assign nxt_tag   = pred_hit ? hit_tgt : seq_tag;
    assign pred_addr = {nxt_tag, {GRP_OFS_W{1'b0}}};
endmodule

// File: rtl/fgp_next_group_chk.sv
// Property checker for fgp_next_group, attached through bind.
// Assumes the internal match vector, replacement pointer and allocate strobe
// are visible under their top-level names.
module fgp_next_group_chk #(
    parameter int PC_W    = 16,
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int OFS_W  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PC_W-1:0]  lk_addr,
    input logic [PC_W-1:0]  pred_addr,
    input logic             pred_hit,
    input logic             upd_en,
    input logic [PC_W-1:0]  upd_addr,
    input logic [PC_W-1:0]  upd_tgt,
    input logic [ENTRIES-1:0] lk_match,
    input logic [ENTRIES-1:0] upd_match,
    input logic [IDX_W-1:0] victim,
    input logic             alloc
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    AST_RESET_ALL_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !pred_hit); // R1

    AST_UPDATE_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(upd_en) &&
         lk_addr[PC_W-1:OFS_W] == $past(upd_addr[PC_W-1:OFS_W]))
        |-> (pred_hit && pred_addr == {$past(upd_tgt[PC_W-1:OFS_W]), {OFS_W{1'b0}}})); // R3

    AST_REWRITE_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(upd_en) && $past(|upd_match)) |-> $stable(victim)); // R5

    AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(alloc))
        |-> (victim == (($past(victim) == LAST) ? '0 : $past(victim) + 1'b1))); // R6

    AST_UNIQUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match)); // R8
endmodule

bind fgp_next_group fgp_next_group_chk #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_addr   (lk_addr),
    .pred_addr (pred_addr),
    .pred_hit  (pred_hit),
    .upd_en    (upd_en),
    .upd_addr  (upd_addr),
    .upd_tgt   (upd_tgt),
    .lk_match  (lk_match),
    .upd_match (upd_match),
    .victim    (victim),
    .alloc     (alloc)
);

// File: tb/tb_fgp_next_group.sv
// Sweep bench for fgp_next_group with a 12-bit address (1024 groups), 32 entries.
module tb_fgp_next_group;
    localparam int PC_W = 12;
    localparam int NENT = 32;
    localparam int NGRP = 1 << (PC_W - 2);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_addr = '0;
    logic [PC_W-1:0] pred_addr;
    logic            pred_hit;
    logic            upd_en = 1'b0;
    logic [PC_W-1:0] upd_addr = '0;
    logic [PC_W-1:0] upd_tgt = '0;

    int n_chk = 0;
    int n_bad = 0;

    // Requirement-level model: slot valid, group tag, successor group, next slot.
    bit m_v   [NENT];
    int m_tag [NENT];
    int m_tgt [NENT];
    int m_rr;

    always #2 clk = ~clk;

    fgp_next_group #(.PC_W(PC_W), .ENTRIES(NENT)) dut (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .pred_addr(pred_addr),
        .pred_hit(pred_hit), .upd_en(upd_en), .upd_addr(upd_addr), .upd_tgt(upd_tgt)
    );

    task automatic model_clear();
        for (int i = 0; i < NENT; i++) m_v[i] = 1'b0;
        m_rr = 0;
    endtask

    // Expected response for a group from the model (R2 miss, R3 hit).
    task automatic expect_of(input int g, output bit eh, output int ea);
        eh = 1'b0;
        ea = ((g + 1) % NGRP) * 4;
        for (int i = 0; i < NENT; i++)
            if (m_v[i] && m_tag[i] == g) begin
                eh = 1'b1;
                ea = m_tgt[i] * 4;
            end
    endtask

    // Compare outputs at the falling edge with the model for group g.
    task automatic check_group(input int g, input string req);
        bit eh; int ea;
        expect_of(g, eh, ea);
        n_chk++;
        if (pred_hit !== eh || pred_addr !== PC_W'(ea)) begin
            n_bad++;
            $display("FAIL %s group %0d: hit=%0b addr=%0d expected hit=%0b addr=%0d",
                     req, g, pred_hit, pred_addr, eh, ea);
        end
    endtask

    // Look up every group once, varying the low offset bits (R7).
    task automatic sweep(input string req);
        for (int g = 0; g < NGRP; g++) begin
            @(posedge clk); #1;
            lk_addr = PC_W'(g * 4 + (g % 4));
            @(negedge clk);
            check_group(g, req);
        end
    endtask

    // One update; checks the same-cycle lookup sees old contents (R4).
    task automatic do_update(input int g, input int tg, input int lo);
        @(posedge clk); #1;
        upd_en   = 1'b1;
        upd_addr = PC_W'(g * 4 + lo);
        upd_tgt  = PC_W'(tg * 4 + (3 - lo));
        lk_addr  = PC_W'(g * 4 + ((lo + 1) % 4));
        @(negedge clk);
        check_group(g, "R4");
        begin
            bit found = 1'b0;
            for (int i = 0; i < NENT; i++)
                if (m_v[i] && m_tag[i] == g) begin
                    m_tgt[i] = tg;
                    found = 1'b1;
                end
            if (!found) begin
                m_v[m_rr] = 1'b1; m_tag[m_rr] = g; m_tgt[m_rr] = tg;
                m_rr = (m_rr + 1) % NENT;
            end
        end
        @(posedge clk); #1;
        upd_en = 1'b0;
        @(negedge clk);
        lk_addr = PC_W'(g * 4);
        #0.5;
        check_group(g, "R3");
    endtask

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        sweep("R1");                              // every group misses, sequential successor incl. wrap (R2)
        for (int i = 0; i < NENT; i++)
            do_update(i * 3 + 5, (i * 37 + 11) % NGRP, i % 4);
        sweep("R8");                              // all 32 groups held at once
        do_update(5 * 3 + 5, 777, 2);             // rewrite in place
        sweep("R5");
        do_update(1000, 4, 1);                    // evicts slot 0
        do_update(1001, 600, 3);                  // evicts slot 1
        sweep("R6");
        @(posedge clk); #1 rst_n = 1'b0;
        model_clear();
        @(posedge clk); #1 rst_n = 1'b1;
        sweep("R1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule